// File: doc/BRIEF.md
# Register-Register Execute Unit

This block carries out the arithmetic, logic, shift, compare and multiply work of a 32-bit processor's register-register instruction class. Each clock it takes an instruction word and the two source operand values. One cycle later it presents the result, a write strobe for the destination register and a flag that marks an encoding it does not support. The register file, instruction fetch, the program counter, memory access and division all live outside the block.

Inside, a decoder turns the instruction fields into a small set of strobes. A datapath computes the selected operation. A thin top registers the outcome. The decoder picks an operation group by masking the upper function field: one group holds the integer ALU operations, the other holds four multiply forms. The multiply forms return either the low product word or the high product word, with the operands taken as signed, unsigned or mixed.

Top module: `rrx_exec_unit`

## Requirements
- R1: While `rstN` is low, `result`, `wrEn` and `illegal` are all 0.
- R2: If bits 6:0 of `instr` are not 7'h33, then one cycle later `illegal`=1, `wrEn`=0 and `result`=0.
- R3: The group value is `instr[31:25]` AND 7'h5F, so bit 30 does not affect group selection. Group 0 is the integer ALU and group 1 is multiply. Any other group value gives `illegal`=1, `wrEn`=0 and `result`=0.
- R4: In group 0, `instr[14:12]`=0 adds the operands. When `instr[30]`=1 it subtracts the second operand from the first instead, modulo 2^32.
- R5: In group 0, `instr[14:12]`=1 shifts left and `instr[14:12]`=5 shifts right. The shift amount is `opB[4:0]`. The right shift is arithmetic when `instr[30]`=1 and logical otherwise, and a shift by 0 returns `opA` unchanged.
- R6: In group 0, `instr[14:12]`=2 gives 1 if `opA` < `opB` as signed values, and `instr[14:12]`=3 gives 1 if `opA` < `opB` as unsigned values. Otherwise each gives 0.
- R7: In group 0, `instr[14:12]` values 4, 6 and 7 give the bitwise XOR, OR and AND of the operands.
- R8: In group 1, `instr[14:12]`=0 returns the low 32 bits of the product. For example, 0xFFFFFFFE times 4 gives 0xFFFFFFF8, and 0xFFFFFFFE times 0xFFFFFFFE gives 0x00000004.
- R9: In group 1, `instr[14:12]` values 1, 2 and 3 return the upper 32 bits of the 64-bit product, with the operands taken as signed×signed, signed `opA`×unsigned `opB`, and unsigned×unsigned. For 0xFFFFFFFE and 4 these give 0xFFFFFFFF, 0xFFFFFFFF and 0x00000003. For 0xFFFFFFFE and 0xFFFFFFFE they give 0x00000000, 0xFFFFFFFE and 0xFFFFFFFC.
- R10: In group 1, `instr[14:12]` values 4 to 7 give `illegal`=1, `wrEn`=0 and `result`=0.
- R11: For a legal encoding, `wrEn`=1 exactly when `instr[11:7]` is nonzero. The result is still presented when `instr[11:7]` is zero.
- R12: Outputs reflect the inputs sampled at the previous rising edge of `clk`, with no other latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word |
| opA | input | 32 | First source operand value |
| opB | input | 32 | Second source operand value |
| result | output | 32 | Registered result |
| wrEn | output | 1 | Destination write strobe |
| illegal | output | 1 | Unsupported encoding flag |

## Verification
The hardest cases to hit are the high multiply words where sign treatment changes the answer. These need operands near 0x80000000 and 0xFFFFFFFE, where signed, mixed and unsigned upper words all differ. Random operands almost never land there. The bench therefore sweeps every operation over a grid of corner values, including the two operand pairs with known products. It also walks every upper function field value, including those with bit 30 set, to cover group masking. Random operands and random encodings then run on top of that grid.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR, OP_SRL, OP_SRA,
    OP_OR, OP_AND, OP_MULLO, OP_MULHSS, OP_MULHSU, OP_MULHUU
  } aluOpE;

  typedef struct packed {
    aluOpE op;
    logic  wrEn;
    logic  illegal;
  } ctrlS;

  localparam logic [6:0] OPC_REGREG = 7'h33;
  localparam logic [6:0] GROUP_MASK = 7'h5F;
endpackage

// File: rtl/rrx_ctrl.sv
module rrx_ctrl
  import rrx_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] fn3,
  input  logic [6:0] fn7,
  input  logic [4:0] rd,
  output ctrlS       strobes
);
  logic [6:0] group;
  logic       alt;

  always_comb begin
    group           = fn7 & GROUP_MASK;
    alt             = fn7[5];
    strobes.op      = OP_ADD;
    strobes.illegal = 1'b1;
    if (opcode == OPC_REGREG) begin
      if (group == 7'd0) begin
        strobes.illegal = 1'b0;
        case (fn3)
          3'd0:    strobes.op = alt ? OP_SUB : OP_ADD;
          3'd1:    strobes.op = OP_SLL;
          3'd2:    strobes.op = OP_SLT;
          3'd3:    strobes.op = OP_SLTU;
          3'd4:    strobes.op = OP_XOR;
          3'd5:    strobes.op = alt ? OP_SRA : OP_SRL;
          3'd6:    strobes.op = OP_OR;
          default: strobes.op = OP_AND;
        endcase
      end else if (group == 7'd1 && !fn3[2]) begin
        strobes.illegal = 1'b0;
        case (fn3[1:0])
          2'd0:    strobes.op = OP_MULLO;
          2'd1:    strobes.op = OP_MULHSS;
          2'd2:    strobes.op = OP_MULHSU;
          default: strobes.op = OP_MULHUU;
        endcase
      end
    end
    strobes.wrEn = !strobes.illegal && (rd != 5'd0);
  end
endmodule

// File: rtl/rrx_datapath.sv
module rrx_datapath
  import rrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aluOpE           op,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);
  localparam int SHW = $clog2(XLEN);
  localparam int PW  = 2 * XLEN + 2;

  logic [SHW-1:0]       shamt;
  logic                 signA, signB;
  logic signed [XLEN:0] mulA, mulB;
  logic signed [PW-1:0] product;

  always_comb begin
    shamt   = opB[SHW-1:0];
    signA   = (op == OP_MULHSS) || (op == OP_MULHSU);
    signB   = (op == OP_MULHSS);
    mulA    = $signed({signA & opA[XLEN-1], opA});
    mulB    = $signed({signB & opB[XLEN-1], opB});
    product = PW'(mulA) * PW'(mulB);
    case (op)
      OP_ADD:    result = opA + opB;
      OP_SUB:    result = opA - opB;
      OP_SLL:    result = opA << shamt;
      OP_SLT:    result = {{(XLEN-1){1'b0}}, $signed(opA) < $signed(opB)};
      OP_SLTU:   result = {{(XLEN-1){1'b0}}, opA < opB};
      OP_XOR:    result = opA ^ opB;
      OP_SRL:    result = opA >> shamt;
      OP_SRA:    result = $unsigned($signed(opA) >>> shamt);
      OP_OR:     result = opA | opB;
      OP_AND:    result = opA & opB;
      OP_MULLO:  result = product[XLEN-1:0];
      default:   result = product[2*XLEN-1:XLEN];
    endcase
  end
endmodule

// File: rtl/rrx_exec_unit.sv
module rrx_exec_unit
  import rrx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instr,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] result,
  output logic        wrEn,
  output logic        illegal
);
  localparam int XLEN = 32;

  ctrlS            strobes;
  logic [XLEN-1:0] dpResult;
  logic            unusedSrcFields;

  assign unusedSrcFields = ^instr[24:15];

  rrx_ctrl i_ctrl (
    .opcode (instr[6:0]),
    .fn3    (instr[14:12]),
    .fn7    (instr[31:25]),
    .rd     (instr[11:7]),
    .strobes(strobes)
  );

  rrx_datapath #(.XLEN(XLEN)) i_dp (
    .op    (strobes.op),
    .opA   (opA),
    .opB   (opB),
    .result(dpResult)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      wrEn    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      result  <= strobes.illegal ? '0 : dpResult;
      wrEn    <= strobes.wrEn;
      illegal <= strobes.illegal;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> (result == '0 && !wrEn && !illegal)); // R1
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (instr[6:0] != OPC_REGREG) |=> (illegal && !wrEn && result == '0)); // R2
  AST_BAD_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    ((instr[31:25] & GROUP_MASK) > 7'd1) |=> (illegal && !wrEn)); // R3
  AST_DIV_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    (instr[6:0] == OPC_REGREG && (instr[31:25] & GROUP_MASK) == 7'd1 && instr[14])
      |=> (illegal && !wrEn && result == '0)); // R10
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    (instr[6:0] == OPC_REGREG && (instr[31:25] & GROUP_MASK) == 7'd0 && instr[14:13] == 2'b01)
      |=> (result[31:1] == '0)); // R6
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (instr[11:7] == 5'd0) |=> !wrEn); // R11
  AST_NO_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !wrEn); // R11
endmodule

// File: tb/test_rrx_exec_unit.sv
module test_rrx_exec_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] opA = 32'h0;
  logic [31:0] opB = 32'h0;
  logic [31:0] result;
  logic        wrEn, illegal;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  rrx_exec_unit i_rrx_exec_unit (
    .clk(clk), .rstN(rstN), .instr(instr), .opA(opA), .opB(opB),
    .result(result), .wrEn(wrEn), .illegal(illegal)
  );

  logic        havePrev = 1'b0;
  logic [31:0] expRes;
  logic        expWr, expIll;
  string       expTag;

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, rd, opc};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [6:0] grp;
    logic [2:0] f3;
    longint     sa, sb, p;
    longint unsigned ua, ub, up;
    grp = ins[31:25] & 7'h5F;
    f3  = ins[14:12];
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = {32'h0, a}; ub = {32'h0, b};
    expIll = 1'b1; expRes = 32'h0; expTag = "R3";
    if (ins[6:0] != 7'h33) expTag = "R2";
    else if (grp == 0) begin
      expIll = 1'b0;
      case (f3)
        0: begin expRes = ins[30] ? a - b : a + b; expTag = "R4"; end
        1: begin expRes = a << b[4:0]; expTag = "R5"; end
        2: begin expRes = (sa < sb) ? 1 : 0; expTag = "R6"; end
        3: begin expRes = (ua < ub) ? 1 : 0; expTag = "R6"; end
        4: begin expRes = a ^ b; expTag = "R7"; end
        5: begin
             expTag = "R5";
             if (ins[30]) begin p = sa >>> b[4:0]; expRes = p[31:0]; end
             else expRes = a >> b[4:0];
           end
        6: begin expRes = a | b; expTag = "R7"; end
        default: begin expRes = a & b; expTag = "R7"; end
      endcase
    end else if (grp == 1) begin
      if (f3 >= 4) expTag = "R10";
      else begin
        expIll = 1'b0;
        case (f3)
          0: begin up = ua * ub; expRes = up[31:0]; expTag = "R8"; end
          1: begin p = sa * sb; expRes = p[63:32]; expTag = "R9"; end
          2: begin p = sa * longint'(ub); expRes = p[63:32]; expTag = "R9"; end
          default: begin up = ua * ub; expRes = up[63:32]; expTag = "R9"; end
        endcase
      end
    end
    expWr = !expIll && ins[11:7] != 0;
    if (!expWr && !expIll) expTag = {expTag, "/R11"};
  endtask

  task automatic compare();
    compared++;
    if (result !== expRes || wrEn !== expWr || illegal !== expIll) begin
      mismatched++;
      $display("FAIL %s R12: got res=%h wr=%b ill=%b exp res=%h wr=%b ill=%b",
               expTag, result, wrEn, illegal, expRes, expWr, expIll);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    if (havePrev) compare();
    instr = ins; opA = a; opB = b;
    model(ins, a, b);
    havePrev = 1'b1;
  endtask

  initial begin
    #300000;
    mismatched++;
    $display("FAIL R12: watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] corners [8];
    logic [2:0]  f3s [8];
    logic [6:0]  f7s [8];
    corners = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                32'hFFFFFFFE, 32'h4, 32'h1F};
    // R1: reset state
    repeat (3) @(negedge clk);
    compared++;
    if (result !== 0 || wrEn !== 0 || illegal !== 0) begin
      mismatched++;
      $display("FAIL R1: got res=%h wr=%b ill=%b exp 0 0 0", result, wrEn, illegal);
    end
    rstN = 1'b1;
    // R8 R9: known product pairs
    for (int f = 0; f < 4; f++) begin
      step(mk(7'h01, 3'(f), 5'd3, 7'h33), 32'hFFFFFFFE, 32'h4);
      step(mk(7'h01, 3'(f), 5'd3, 7'h33), 32'hFFFFFFFE, 32'hFFFFFFFE);
    end
    // R4-R10 corner grid over every group/function combination
    f7s = '{7'h00, 7'h20, 7'h01, 7'h21, 7'h02, 7'h40, 7'h60, 7'h7F};
    for (int g = 0; g < 8; g++)
      for (int f = 0; f < 8; f++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            step(mk(f7s[g], 3'(f), 5'd5, 7'h33), corners[i], corners[j]);
    // R11: rd zero still presents result without write
    step(mk(7'h00, 3'd0, 5'd0, 7'h33), 32'd7, 32'd9);
    step(mk(7'h01, 3'd3, 5'd0, 7'h33), 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R2: other opcodes
    step(mk(7'h00, 3'd0, 5'd1, 7'h13), 32'd1, 32'd2);
    step(mk(7'h01, 3'd0, 5'd1, 7'h3B), 32'd3, 32'd2);
    // R5: shift amount uses only low bits
    step(mk(7'h20, 3'd5, 5'd1, 7'h33), 32'h80000000, 32'hFFFFFFE0);
    step(mk(7'h00, 3'd1, 5'd1, 7'h33), 32'h1, 32'h0000003F);
    // random operands and encodings
    f3s = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(mk((n % 3 == 0) ? 7'(r[31:25]) : {1'b0, r[25], 4'b0, r[24]},
              f3s[r[2:0]], r[7:3], (n % 17 == 0) ? 7'(r[14:8]) : 7'h33),
           $urandom, $urandom);
    end
    @(negedge clk);
    compare();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule